// File: doc/BRIEF.md
# Serial Synthesizer Programming Port

This block takes the three-wire configuration stream that programs a frequency synthesizer and turns it into parallel settings held in registers. A host drives a serial clock, a data line and a load strobe. Bits enter a 19-bit shift register on each rising edge of the serial clock, most significant bit first. The bit shifted in last is a control flag, and it decides which of two holding latches the word is written to when the load strobe rises.

The reference latch holds the reference division ratio and three configuration flags: prescaler modulus select, phase polarity and monitor select. The divider latch holds the swallow value and the main counter value. Every input is brought into the system clock domain through a synchroniser. A write that carries a ratio below the legal minimum is refused, and a sticky error flag is raised. The port has no power-state gating, so a write lands the same way whether or not the synthesizer around it is in a power-saving state.

Top module: `pll_cfg_port`

## Requirements
- R1: Serial bits are captured on every rising edge of `serClk`, most significant bit first. The last bit captured becomes word bit 0, which is the control flag.
- R2: On a load with control flag 1, the reference latch takes its fields from the word. `refRatio` comes from word bits 14..1, with bit 1 as the ratio LSB. `prescSmall` comes from bit 15, `phaseInv` from bit 16 and `monSel` from bit 17. `swallow` and `mainCnt` keep their values.
- R3: On a load with control flag 0, the divider latch takes its fields from the word. `swallow` comes from word bits 7..1, with bit 1 as the LSB. `mainCnt` comes from word bits 18..8, with bit 8 as the LSB. The reference outputs keep their values.
- R4: A reference write needs only 18 serial clocks. Word bit 18 has no effect on any reference output.
- R5: A reference write whose ratio field is below 5 sets `ratioErr`, and all four reference outputs keep their previous values.
- R6: A divider write whose main counter field is below 5 sets `ratioErr`, and the divider outputs keep their values. Any swallow value from 0 to 127 is accepted.
- R7: Boundary ratios are accepted without an error: reference 5 and 16383, main counter 5 and 2047.
- R8: Each rising edge of `loadEn` causes exactly one transfer. Words shifted in while `loadEn` stays high do not reach the outputs until the next rising edge.
- R9: Reset clears every output to 0 and clears `ratioErr`. Once `ratioErr` is set, only reset clears it. Later legal writes leave it set.
- R10: Serial clocks with no load edge leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial bit clock (asynchronous) |
| serData | input | 1 | Serial data, MSB first |
| loadEn | input | 1 | Load strobe; its rising edge transfers the word |
| refRatio | output | 14 | Reference division ratio |
| prescSmall | output | 1 | 1 selects the smaller prescaler modulus pair |
| phaseInv | output | 1 | Phase comparator polarity |
| monSel | output | 1 | Monitor output select |
| swallow | output | 7 | Swallow counter value |
| mainCnt | output | 11 | Main counter value |
| ratioErr | output | 1 | Sticky flag for a refused write |

## Verification
The hardest situation to create from the ports is a load strobe that stays high while a second complete word is clocked in. A level-sensitive design would copy the second word straight through, so the stimulus does exactly that. It raises `loadEn` after the first word and shifts a full conflicting word while the strobe is held. The reference model then expects the first word's values on every clock until a fresh rising edge arrives. The stream also mixes 18- and 19-clock reference writes with a set top bit. It places refused writes between legal ones, so stale shift-register bits and the sticky flag are both exercised.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;

  // Strobes handed from the control side to the datapath
  typedef struct packed {
    logic shift;    // one serial bit to capture this cycle
    logic load;     // load strobe rising edge seen this cycle
    logic dataBit;  // synchronised serial data
  } cfg_strobe_t;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int STAGES = 2
) (
  input  logic sysClk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/cfg_ctrl.sv
module cfg_ctrl
  import pll_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        sysClk,
  input  logic        rstN,
  input  logic        serClk,
  input  logic        serData,
  input  logic        loadEn,
  output cfg_strobe_t strobe
);
  localparam int NUM_IN = 3;

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] syncIn;
  logic              prevClk;
  logic              prevLoad;

  assign rawIn = {loadEn, serData, serClk};

  // Clock, data and load pass through equal-length chains so they stay aligned
  for (genvar g = 0; g < NUM_IN; g++) begin : g_sync
    cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .sysClk(sysClk),
      .rstN  (rstN),
      .din   (rawIn[g]),
      .dout  (syncIn[g])
    );
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      prevClk  <= 1'b0;
      prevLoad <= 1'b0;
    end else begin
      prevClk  <= syncIn[0];
      prevLoad <= syncIn[2];
    end
  end

  always_comb begin
    strobe.shift   = syncIn[0] & ~prevClk;
    strobe.dataBit = syncIn[1];
    strobe.load    = syncIn[2] & ~prevLoad;
  end
endmodule

// File: rtl/cfg_datapath.sv
module cfg_datapath
  import pll_cfg_pkg::*;
#(
  parameter int REF_BITS  = 14,
  parameter int SWAL_BITS = 7,
  parameter int MAIN_BITS = 11,
  parameter int MIN_RATIO = 5
) (
  input  logic                 sysClk,
  input  logic                 rstN,
  input  cfg_strobe_t          strobe,
  output logic [REF_BITS-1:0]  refRatio,
  output logic                 prescSmall,
  output logic                 phaseInv,
  output logic                 monSel,
  output logic [SWAL_BITS-1:0] swallow,
  output logic [MAIN_BITS-1:0] mainCnt,
  output logic                 ratioErr
);
  localparam int SHIFT_LEN = 1 + SWAL_BITS + MAIN_BITS;
  localparam int SEL_POS   = REF_BITS + 1;
  localparam int POL_POS   = REF_BITS + 2;
  localparam int MON_POS   = REF_BITS + 3;
  localparam logic [REF_BITS-1:0]  REF_MIN  = REF_BITS'(MIN_RATIO);
  localparam logic [MAIN_BITS-1:0] MAIN_MIN = MAIN_BITS'(MIN_RATIO);

  logic [SHIFT_LEN-1:0] shReg;
  logic                 ctrlBit;
  logic [REF_BITS-1:0]  candRef;
  logic [SWAL_BITS-1:0] candSwal;
  logic [MAIN_BITS-1:0] candMain;
  logic                 refOk;
  logic                 mainOk;
  logic                 refWrite;
  logic                 divWrite;

  // Serial capture: new bit enters at position 0, older bits move up
  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN)             shReg <= '0;
    else if (strobe.shift) shReg <= {shReg[SHIFT_LEN-2:0], strobe.dataBit};
  end

  // Field decode of the held word
  always_comb begin
    ctrlBit  = shReg[0];
    candRef  = shReg[REF_BITS:1];
    candSwal = shReg[SWAL_BITS:1];
    candMain = shReg[SHIFT_LEN-1:SWAL_BITS+1];
    refOk    = candRef >= REF_MIN;
    mainOk   = candMain >= MAIN_MIN;
    refWrite = strobe.load & ctrlBit & refOk;
    divWrite = strobe.load & ~ctrlBit & mainOk;
  end

  // Reference latch with its configuration flags
  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      refRatio   <= '0;
      prescSmall <= 1'b0;
      phaseInv   <= 1'b0;
      monSel     <= 1'b0;
    end else if (refWrite) begin
      refRatio   <= candRef;
      prescSmall <= shReg[SEL_POS];
      phaseInv   <= shReg[POL_POS];
      monSel     <= shReg[MON_POS];
    end
  end

  // Divider latch
  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      swallow <= '0;
      mainCnt <= '0;
    end else if (divWrite) begin
      swallow <= candSwal;
      mainCnt <= candMain;
    end
  end

  // Sticky refusal flag
  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN)                                          ratioErr <= 1'b0;
    else if (strobe.load && !(ctrlBit ? refOk : mainOk)) ratioErr <= 1'b1;
  end

  // R9: the refusal flag never drops without reset
  p_err_sticky_r9: assert property (@(posedge sysClk) disable iff (!rstN)
    ratioErr |=> ratioErr);

  // R3: reference settings move only on a load with control flag set
  p_ref_hold_r3: assert property (@(posedge sysClk) disable iff (!rstN)
    !(strobe.load && ctrlBit) |=> $stable({refRatio, prescSmall, phaseInv, monSel}));

  // R2: divider settings move only on a load with control flag clear
  p_div_hold_r2: assert property (@(posedge sysClk) disable iff (!rstN)
    !(strobe.load && !ctrlBit) |=> $stable({swallow, mainCnt}));

  // R5: a held reference ratio is either the reset value or legal
  p_ref_legal_r5: assert property (@(posedge sysClk) disable iff (!rstN)
    (refRatio != '0) |-> (refRatio >= REF_MIN));

  // R6: a held main counter value is either the reset value or legal
  p_main_legal_r6: assert property (@(posedge sysClk) disable iff (!rstN)
    (mainCnt != '0) |-> (mainCnt >= MAIN_MIN));
endmodule

// File: rtl/pll_cfg_port.sv
module pll_cfg_port
  import pll_cfg_pkg::*;
#(
  parameter int REF_BITS    = 14,
  parameter int SWAL_BITS   = 7,
  parameter int MAIN_BITS   = 11,
  parameter int MIN_RATIO   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 sysClk,
  input  logic                 rstN,
  input  logic                 serClk,
  input  logic                 serData,
  input  logic                 loadEn,
  output logic [REF_BITS-1:0]  refRatio,
  output logic                 prescSmall,
  output logic                 phaseInv,
  output logic                 monSel,
  output logic [SWAL_BITS-1:0] swallow,
  output logic [MAIN_BITS-1:0] mainCnt,
  output logic                 ratioErr
);
  cfg_strobe_t strobe;

  cfg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .sysClk (sysClk),
    .rstN   (rstN),
    .serClk (serClk),
    .serData(serData),
    .loadEn (loadEn),
    .strobe (strobe)
  );

  cfg_datapath #(
    .REF_BITS (REF_BITS),
    .SWAL_BITS(SWAL_BITS),
    .MAIN_BITS(MAIN_BITS),
    .MIN_RATIO(MIN_RATIO)
  ) u_dp (
    .sysClk    (sysClk),
    .rstN      (rstN),
    .strobe    (strobe),
    .refRatio  (refRatio),
    .prescSmall(prescSmall),
    .phaseInv  (phaseInv),
    .monSel    (monSel),
    .swallow   (swallow),
    .mainCnt   (mainCnt),
    .ratioErr  (ratioErr)
  );
endmodule

// File: tb/sim_pll_cfg_port.sv
module sim_pll_cfg_port;
  logic        sysClk = 1'b0;
  logic        rstN = 1'b0;
  logic        serClk = 1'b0;
  logic        serData = 1'b0;
  logic        loadEn = 1'b0;
  logic [13:0] refRatio;
  logic        prescSmall, phaseInv, monSel, ratioErr;
  logic [6:0]  swallow;
  logic [10:0] mainCnt;

  int errors = 0;
  int checks = 0;
  bit busy = 1'b1;
  bit sentBits[$];

  // Behavioural model state
  int mRef = 0, mSel = 0, mPol = 0, mMon = 0, mSwal = 0, mMain = 0, mErr = 0;

  always #5 sysClk = ~sysClk;

  pll_cfg_port u0 (
    .sysClk(sysClk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .loadEn(loadEn), .refRatio(refRatio), .prescSmall(prescSmall),
    .phaseInv(phaseInv), .monSel(monSel), .swallow(swallow),
    .mainCnt(mainCnt), .ratioErr(ratioErr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int bitAt(input int k);
    int idx = sentBits.size() - 1 - k;
    return (idx >= 0) ? int'(sentBits[idx]) : 0;
  endfunction

  function automatic int fieldAt(input int lo, input int n);
    int v = 0;
    for (int k = 0; k < n; k++) v |= bitAt(lo + k) << k;
    return v;
  endfunction

  // Model of one transfer, taken from the history of bits sent
  task automatic modelLoad();
    if (bitAt(0) == 1) begin
      if (fieldAt(1, 14) >= 5) begin
        mRef = fieldAt(1, 14); mSel = bitAt(15); mPol = bitAt(16); mMon = bitAt(17);
      end else mErr = 1;
    end else begin
      if (fieldAt(8, 11) >= 5) begin
        mSwal = fieldAt(1, 7); mMain = fieldAt(8, 11);
      end else mErr = 1;
    end
  endtask

  // Compare every clock outside transfer windows
  always @(negedge sysClk) begin
    if (!busy && rstN) begin
      chk("R2 refRatio", int'(refRatio), mRef);
      chk("R2 prescSmall", int'(prescSmall), mSel);
      chk("R2 phaseInv", int'(phaseInv), mPol);
      chk("R2 monSel", int'(monSel), mMon);
      chk("R3 swallow", int'(swallow), mSwal);
      chk("R3 mainCnt", int'(mainCnt), mMain);
      chk("R9 ratioErr", int'(ratioErr), mErr);
    end
  end

  task automatic sendBits(input logic [18:0] w, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) begin
      @(negedge sysClk); serData = w[i];
      repeat (4) @(negedge sysClk); serClk = 1'b1;
      sentBits.push_back(w[i]);
      repeat (4) @(negedge sysClk); serClk = 1'b0;
      repeat (2) @(negedge sysClk);
    end
    repeat (4) @(negedge sysClk);
  endtask

  task automatic riseLoad();
    @(negedge sysClk); busy = 1'b1; loadEn = 1'b1;
    repeat (8) @(negedge sysClk);
    modelLoad();
    busy = 1'b0;
  endtask

  task automatic pulseLoad();
    riseLoad();
    @(negedge sysClk); loadEn = 1'b0;
    repeat (6) @(negedge sysClk);
  endtask

  function automatic logic [18:0] refWord(input int r, input int s, input int p,
                                          input int m, input int top);
    return {top[0], m[0], p[0], s[0], r[13:0], 1'b1};
  endfunction

  function automatic logic [18:0] divWord(input int n, input int a);
    return {n[10:0], a[6:0], 1'b0};
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge sysClk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge sysClk);
    rstN = 1'b1;
    @(negedge sysClk);
    // R9 reset state
    chk("R9 reset refRatio", int'(refRatio), 0);
    chk("R9 reset mainCnt", int'(mainCnt), 0);
    chk("R9 reset ratioErr", int'(ratioErr), 0);
    busy = 1'b0;

    // R1 R2: 18-clock reference write
    sendBits(refWord(1000, 1, 0, 1, 0), 18);
    pulseLoad();
    chk("R1 R2 refRatio", int'(refRatio), 1000);
    chk("R2 prescSmall", int'(prescSmall), 1);
    chk("R2 monSel", int'(monSel), 1);
    chk("R2 divider untouched", int'(mainCnt), 0);

    // R3: divider write
    sendBits(divWord(1234, 37), 19);
    pulseLoad();
    chk("R3 swallow", int'(swallow), 37);
    chk("R3 mainCnt", int'(mainCnt), 1234);
    chk("R3 reference untouched", int'(refRatio), 1000);

    // R4 R7: 19-clock reference write, bit 18 set, minimum ratio
    sendBits(refWord(5, 0, 1, 0, 1), 19);
    pulseLoad();
    chk("R4 R7 refRatio min", int'(refRatio), 5);
    chk("R4 phaseInv", int'(phaseInv), 1);
    chk("R4 monSel bit18 ignored", int'(monSel), 0);
    chk("R7 no error", int'(ratioErr), 0);

    // R6 R7: swallow extremes and main counter bounds
    sendBits(divWord(2047, 127), 19);
    pulseLoad();
    chk("R7 mainCnt max", int'(mainCnt), 2047);
    chk("R6 swallow 127", int'(swallow), 127);
    sendBits(divWord(5, 0), 19);
    pulseLoad();
    chk("R7 mainCnt min", int'(mainCnt), 5);
    chk("R6 swallow 0", int'(swallow), 0);
    sendBits(refWord(16383, 1, 1, 1, 0), 18);
    pulseLoad();
    chk("R7 refRatio max", int'(refRatio), 16383);
    chk("R7 still no error", int'(ratioErr), 0);

    // R10: shifting without a load edge
    sendBits(divWord(700, 9), 19);
    repeat (10) @(negedge sysClk);
    chk("R10 mainCnt unchanged", int'(mainCnt), 5);
    chk("R10 refRatio unchanged", int'(refRatio), 16383);

    // R8: hold load high while a second word arrives
    sendBits(refWord(300, 0, 0, 1, 0), 18);
    riseLoad();
    sendBits(refWord(900, 1, 1, 0, 0), 18);
    repeat (6) @(negedge sysClk);
    chk("R8 held load keeps first word", int'(refRatio), 300);
    @(negedge sysClk); loadEn = 1'b0;
    repeat (6) @(negedge sysClk);
    chk("R8 no transfer on fall", int'(refRatio), 300);
    pulseLoad();
    chk("R8 new edge transfers", int'(refRatio), 900);

    // R5: illegal reference ratio
    sendBits(refWord(4, 0, 0, 1, 0), 18);
    pulseLoad();
    chk("R5 ratioErr set", int'(ratioErr), 1);
    chk("R5 refRatio kept", int'(refRatio), 900);
    chk("R5 prescSmall kept", int'(prescSmall), 1);

    // R6: illegal main counter
    sendBits(divWord(3, 50), 19);
    pulseLoad();
    chk("R6 mainCnt kept", int'(mainCnt), 5);
    chk("R6 swallow kept", int'(swallow), 0);

    // R9: sticky across a legal write, cleared by reset
    sendBits(divWord(100, 20), 19);
    pulseLoad();
    chk("R9 sticky after legal write", int'(ratioErr), 1);
    chk("R9 legal write applied", int'(mainCnt), 100);
    busy = 1'b1;
    @(negedge sysClk); rstN = 1'b0;
    repeat (3) @(negedge sysClk);
    rstN = 1'b1;
    @(negedge sysClk);
    chk("R9 reset clears ratioErr", int'(ratioErr), 0);
    chk("R9 reset clears refRatio", int'(refRatio), 0);
    repeat (4) @(negedge sysClk);
    summary();
  end
endmodule